// File: doc/BRIEF.md
# Communication Cell Access Decoder

This block stands between a memory-mapped request bus and an array of inter-thread communication cells. Each request carries an address inside the cell storage window. The block splits that address into two parts. The low bits give an access view, which tells the cell how to treat the access: raw data, tag control, blocking or non-blocking queue operations, and blocking or non-blocking counting-semaphore operations. The upper bits give the cell index. The block then forwards the request to the selected cell, or answers it itself.

Queue cells take the lower indices and semaphore cells take the ones above them. Both counts are parameters. The block also holds a small status word, reached through a reserved view code. It carries sticky error flags, a three-bit grain field that sets the cell stride, and the total cell count, which is read-only. The block rejects narrow accesses with a bus error.

Every accepted request gets exactly one response, one cycle after acceptance. For a forwarded read, the response carries the data the cell returned.

Top module: `cell_view_decoder`

## Requirements
- R1: The access view is `req_addr[6:3]`. View codes 0 through 5 are cell views. A request of adequate size with a cell view raises `cell_valid` and presents that code on `cell_view`.
- R2: The cell index is `req_addr >> (7 + G)`, where G is the grain field of the status word. The stride is therefore 128 bytes when G is 0, and doubles for each step of G.
- R3: A computed index at or above the total cell count (`N_FIFO + N_SEM`) is replaced by the last index, `N_FIFO + N_SEM - 1`.
- R4: `req_size` codes 0 (1 byte) and 1 (2 bytes) are narrow, while codes 2 and above are accepted. A narrow request reaches no cell. Its response has `rsp_err` = 1 and `rsp_rdata` = 0, and it sets status bit 2, which stays set until it is cleared.
- R5: View code 15 reads the status word. Error flags sit in bits [2:0], the grain in bits [10:8], and the cell count from bit 16 upward. After reset the word reads as the cell count shifted left by 16.
- R6: A write to view 15 clears each error bit [2:0] whose data bit is 1. It loads the grain from data bits [10:8]. No other status bit changes.
- R7: A read with a view code outside 0–5 and 15 responds with `rsp_err` = 1 and all-ones data. A write with such a code responds with `rsp_err` = 0 and reaches no cell. It also leaves the status word unchanged.
- R8: `cell_is_fifo` is 1 exactly when the forwarded index is below `N_FIFO`.
- R9: While a request is forwarded, `req_ready` follows `cell_ready`; otherwise `req_ready` is 1. Each accepted request produces one `rsp_valid` pulse in the following cycle. A cell read returns `cell_rdata`, and every write response carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Offset inside the storage window |
| req_size | input | 3 | log2 of access bytes |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Bus error response |
| rsp_rdata | output | DATA_W | Read data |
| cell_valid | output | 1 | Request forwarded to a cell |
| cell_ready | input | 1 | Selected cell can take the request |
| cell_idx | output | IDX_W | Selected cell |
| cell_view | output | 4 | View code for the cell |
| cell_is_fifo | output | 1 | Selected cell is a queue cell |
| cell_write | output | 1 | Forwarded direction |
| cell_wdata | output | DATA_W | Forwarded write data |
| cell_rdata | input | DATA_W | Cell read data, same cycle |

## Verification
The bench builds the block with three queue cells and two semaphore cells, so the total of five is not a power of two. With that count, clamping happens strictly between two power-of-two boundaries, and the queue/semaphore split falls at an index that is not aligned. The bench uses a 20-bit address so that every grain value, up to a 16 KiB stride, can still produce indices both inside and past the cell array.

// File: rtl/cvd_pkg.sv
package cvd_pkg;
    localparam int          STRIDE_BASE = 7;
    localparam logic [3:0]  VIEW_RAW    = 4'd0;
    localparam logic [3:0]  VIEW_TAG    = 4'd1;
    localparam logic [3:0]  VIEW_EF_BLK = 4'd2;
    localparam logic [3:0]  VIEW_EF_TRY = 4'd3;
    localparam logic [3:0]  VIEW_PV_BLK = 4'd4;
    localparam logic [3:0]  VIEW_PV_TRY = 4'd5;
    localparam logic [3:0]  VIEW_STATUS = 4'd15;
    localparam logic [2:0]  SIZE_MIN_OK = 3'd2;
    localparam int          STAT_GRAIN_LSB = 8;
    localparam int          STAT_COUNT_LSB = 16;

    function automatic logic view_is_cell(input logic [3:0] v);
        return v <= VIEW_PV_TRY;
    endfunction
endpackage

// File: rtl/cvd_index.sv
module cvd_index #(
    parameter int ADDR_W  = 20,
    parameter int N_CELLS = 32,
    parameter int IDX_W   = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        grain,
    output logic [IDX_W-1:0]  idx
);
    import cvd_pkg::*;

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N_CELLS - 1);

    logic [ADDR_W-1:0] raw;

    always_comb begin
        raw = addr >> (STRIDE_BASE + int'(grain));
        if (raw >= LAST) begin
            idx = IDX_W'(N_CELLS - 1);
        end else begin
            idx = raw[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/cvd_status.sv
module cvd_status #(
    parameter int N_CELLS = 32,
    parameter int DATA_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              narrow_evt,
    output logic [2:0]        grain,
    output logic [DATA_W-1:0] status_word
);
    import cvd_pkg::*;

    localparam int CNT_W = $clog2(N_CELLS + 1);

    typedef struct packed {
        logic [2:0] err;
        logic [2:0] grain;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.err   = st_q.err & ~wdata[2:0];
            st_d.grain = wdata[STAT_GRAIN_LSB +: 3];
        end
        if (narrow_evt) begin
            st_d.err[2] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status_word = '0;
        status_word[2:0] = st_q.err;
        status_word[STAT_GRAIN_LSB +: 3] = st_q.grain;
        status_word[STAT_COUNT_LSB +: CNT_W] = CNT_W'(N_CELLS);
    end

    assign grain = st_q.grain;

    // R4: a narrow access leaves error bit 2 set
    a_r4_sticky_err: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_evt |=> st_q.err[2]);
    // R6: grain moves only on a status write
    a_r6_grain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.grain));
    // R6: error bit 2 written as one clears when no new narrow access arrives
    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[2] && !narrow_evt) |=> !st_q.err[2]);
endmodule

// File: rtl/cell_view_decoder.sv
module cell_view_decoder #(
    parameter int N_FIFO = 16,
    parameter int N_SEM  = 16,
    parameter int ADDR_W = 20,
    parameter int DATA_W = 64,
    localparam int N_CELLS = N_FIFO + N_SEM,
    localparam int IDX_W   = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              cell_valid,
    input  logic              cell_ready,
    output logic [IDX_W-1:0]  cell_idx,
    output logic [3:0]        cell_view,
    output logic              cell_is_fifo,
    output logic              cell_write,
    output logic [DATA_W-1:0] cell_wdata,
    input  logic [DATA_W-1:0] cell_rdata
);
    import cvd_pkg::*;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [3:0]        view;
    logic              narrow, is_cell, is_status, accept;
    logic [2:0]        grain;
    logic [DATA_W-1:0] status_word;
    logic              stat_wr, narrow_evt;

    cvd_index #(.ADDR_W(ADDR_W), .N_CELLS(N_CELLS), .IDX_W(IDX_W)) u_index (
        .addr  (req_addr),
        .grain (grain),
        .idx   (cell_idx)
    );

    cvd_status #(.N_CELLS(N_CELLS), .DATA_W(DATA_W)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (stat_wr),
        .wdata       (req_wdata),
        .narrow_evt  (narrow_evt),
        .grain       (grain),
        .status_word (status_word)
    );

    always_comb begin
        view       = req_addr[6:3];
        narrow     = req_size < SIZE_MIN_OK;
        is_cell    = view_is_cell(view);
        is_status  = view == VIEW_STATUS;
        cell_valid = req_valid && !narrow && is_cell;
        req_ready  = cell_valid ? cell_ready : 1'b1;
        accept     = req_valid && req_ready;
        stat_wr    = accept && !narrow && is_status && req_write;
        narrow_evt = accept && narrow;

        cell_view    = view;
        cell_write   = req_write;
        cell_wdata   = req_wdata;
        cell_is_fifo = int'(cell_idx) < N_FIFO;

        rsp_d       = '0;
        rsp_d.valid = accept;
        if (accept) begin
            if (narrow) begin
                rsp_d.err = 1'b1;
            end else if (is_cell) begin
                rsp_d.rdata = req_write ? '0 : cell_rdata;
            end else if (is_status) begin
                rsp_d.rdata = req_write ? '0 : status_word;
            end else if (!req_write) begin
                rsp_d.err   = 1'b1;
                rsp_d.rdata = '1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;

    // R4: narrow requests are never forwarded
    a_r4_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size < SIZE_MIN_OK) |-> !cell_valid);
    // R7: undefined-view reads answer with an error and all ones
    a_r7_undef_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && req_size >= SIZE_MIN_OK &&
         req_addr[6:3] > VIEW_PV_TRY && req_addr[6:3] != VIEW_STATUS)
        |=> (rsp_valid && rsp_err && (&rsp_rdata)));
    // R9: one response per accepted request
    a_r9_one_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid);
    // R9: a stalled cell holds the request
    a_r9_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_valid && !cell_ready) |-> !req_ready);
endmodule

// File: tb/test_cell_view_decoder.sv
module test_cell_view_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 3;
    localparam int NS = 2;
    localparam int NC = NF + NS;
    localparam int AW = 20;
    localparam int DW = 64;
    localparam int IW = $clog2(NC);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]    req_size = 3'd3;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid, rsp_err;
    logic [DW-1:0] rsp_rdata, cell_wdata, cell_rdata;
    logic          cell_valid, cell_is_fifo, cell_write;
    logic          cell_ready = 1'b1;
    logic [IW-1:0] cell_idx;
    logic [3:0]    cell_view;

    int vecs = 0;
    int errs = 0;
    logic [2:0] grain_m = 3'd0;
    logic [2:0] err_m = 3'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // cell model: data names the cell and view it came from
    assign cell_rdata = 64'hCE11_0000_0000_0000 | (DW'(cell_idx) << 8) | DW'(cell_view);

    cell_view_decoder #(.N_FIFO(NF), .N_SEM(NS), .ADDR_W(AW), .DATA_W(DW)) i_cell_view_decoder (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .cell_valid(cell_valid), .cell_ready(cell_ready), .cell_idx(cell_idx),
        .cell_view(cell_view), .cell_is_fifo(cell_is_fifo), .cell_write(cell_write),
        .cell_wdata(cell_wdata), .cell_rdata(cell_rdata)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int exp_idx(input logic [AW-1:0] a);
        logic [AW-1:0] r;
        r = a >> (7 + int'(grain_m));
        return (r >= AW'(NC - 1)) ? NC - 1 : int'(r);
    endfunction

    function automatic logic [DW-1:0] status_m();
        return (DW'(NC) << 16) | (DW'(grain_m) << 8) | DW'(err_m);
    endfunction

    function automatic logic [DW-1:0] cell_m(input int idx, input logic [3:0] v);
        return 64'hCE11_0000_0000_0000 | (DW'(idx) << 8) | DW'(v);
    endfunction

    task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [2:0] sz,
                        input logic [DW-1:0] d);
        logic [3:0]    v;
        logic          nar, fwd, e_err;
        logic [DW-1:0] e_data;
        int            ei;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        v   = a[6:3];
        nar = sz < 3'd2;
        fwd = !nar && v <= 4'd5;
        ei  = exp_idx(a);
        #1;
        chk(nar ? "R4 no forward" : "R1 cell_valid", DW'(cell_valid), DW'(fwd));
        if (fwd) begin
            chk("R1 cell_view", DW'(cell_view), DW'(v));
            chk("R2/R3 cell_idx", DW'(cell_idx), DW'(ei));
            chk("R8 cell_is_fifo", DW'(cell_is_fifo), DW'(ei < NF));
        end
        chk("R9 req_ready", DW'(req_ready), 1);
        e_err = 1'b0; e_data = '0;
        if (nar) begin
            e_err = 1'b1;
        end else if (fwd) begin
            e_data = wr ? '0 : cell_m(ei, v);
        end else if (v == 4'd15) begin
            e_data = wr ? '0 : status_m();
        end else if (!wr) begin
            e_err = 1'b1; e_data = '1;
        end
        if (nar) err_m[2] = 1'b1;
        else if (v == 4'd15 && wr) begin
            err_m   = err_m & ~d[2:0];
            grain_m = d[10:8];
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 rsp_valid", DW'(rsp_valid), 1);
        chk(nar ? "R4 rsp_err" : "R7 rsp_err", DW'(rsp_err), DW'(e_err));
        chk(nar ? "R4 rsp_rdata" : (fwd ? "R9 rsp_rdata" : "R5/R7 rsp_rdata"), rsp_rdata, e_data);
    endtask

    function automatic logic [AW-1:0] mk(input int idx, input int v);
        return AW'((idx << (7 + int'(grain_m))) | (v << 3));
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset rsp_valid", DW'(rsp_valid), 0);
        // R5 reset value
        xfer(1'b0, mk(0, 15), 3'd3, '0);
        chk("R5 reset status", status_m(), DW'(NC) << 16);
        // R1 R2 direct routing at grain 0
        xfer(1'b0, mk(0, 0), 3'd3, '0);
        xfer(1'b0, mk(3, 2), 3'd2, '0);
        xfer(1'b1, mk(2, 5), 3'd3, 64'h1234);
        // R3 clamping
        xfer(1'b0, mk(9, 4), 3'd3, '0);
        xfer(1'b0, AW'(20'hFFFF8), 3'd3, '0);
        // R6 grain change then stride check R2
        xfer(1'b1, mk(0, 15), 3'd3, 64'h200);
        xfer(1'b0, mk(0, 15), 3'd3, '0);
        xfer(1'b0, AW'(512 + 8), 3'd3, '0);
        xfer(1'b0, AW'(384), 3'd3, '0);
        // R4 narrow accesses, the write must not load the grain
        xfer(1'b0, mk(1, 0), 3'd0, '0);
        xfer(1'b1, mk(0, 15), 3'd1, 64'h700);
        xfer(1'b0, mk(0, 15), 3'd3, '0);
        // R6 clear and read-only count
        xfer(1'b1, mk(0, 15), 3'd2, 64'hFFFF_0000 | 64'h4 | 64'h200);
        xfer(1'b0, mk(0, 15), 3'd3, '0);
        // R7 undefined views
        xfer(1'b0, mk(1, 7), 3'd3, '0);
        xfer(1'b1, mk(1, 9), 3'd3, 64'hFFFF);
        xfer(1'b0, mk(0, 15), 3'd3, '0);
        // R9 backpressure
        @(negedge clk);
        cell_ready = 1'b0; req_valid = 1'b1; req_write = 1'b0;
        req_addr = mk(1, 1); req_size = 3'd3;
        #1;
        chk("R9 req_ready stalled", DW'(req_ready), 0);
        @(negedge clk);
        chk("R9 no rsp when stalled", DW'(rsp_valid), 0);
        req_valid = 1'b0; cell_ready = 1'b1;
        // R8 split
        xfer(1'b0, mk(2, 3), 3'd3, '0);
        xfer(1'b0, mk(3, 3), 3'd3, '0);
        // random mix
        for (int n = 0; n < 400; n++) begin
            int            r;
            logic [AW-1:0] a;
            logic [3:0]    v;
            r = int'($urandom % 16);
            v = (r < 10) ? 4'($urandom % 6) : ((r < 13) ? 4'd15 : 4'($urandom % 16));
            if ($urandom % 3 == 0) a = AW'($urandom);
            else a = mk(int'($urandom % 8), 0);
            a[6:3] = v;
            xfer(1'($urandom), a, 3'($urandom), (v == 4'd15) ? DW'($urandom % 2048) :
                 {32'($urandom), 32'($urandom)});
        end
        finish_run();
    end
endmodule